// File: doc/BRIEF.md
# JTAG Debug Bus-Access Data Register

This block is the data-register side of a debug bridge. It lets a JTAG host read and write a system bus. An external TAP controller provides one-cycle capture, shift and update strobes together with the serial input. The block owns a 33-bit scan path and a small bus-master port. The lower 32 bits of the scan path carry transfer data. The top bit is a streaming flag: when the host sets it, the next transfer goes to the following word address, so the address does not have to be reloaded.

A separate command register, which is outside this block, provides the start address, the direction and the transfer size. It pulses a load strobe when it changes. A load in the read direction starts a read at once, and the next capture presents the returned data. In the write direction, each update starts a bus write with the data that was just shifted in. Byte and half-word values are right-justified in the scan field. On the bus they sit in big-endian lane order, so address offset 0 occupies the most significant bits. An update that arrives while a request is still waiting for acknowledge is held and issued once, as soon as the acknowledge arrives.

Top module: `jtag_dr_bus_access`

## Requirements
- R1: After reset, bus_req is 0 and tdo is 0.
- R2: A capture loads the scan path with the last read data in bits 31:0 and 0 in bit 32. Each shift cycle moves the path one place toward bit 0: tdi enters at bit 32 and tdo shows bit 0.
- R3: A command load with cmd_write=0 starts a read with the loaded address and size. The extracted result appears in bits 31:0 at the next capture.
- R4: An update in the write direction starts one write, using the current address and size and the lane-placed value of scan bits 31:0.
- R5: Size code 0 (byte): scan bits 7:0 map to bus bits [31-8*k -: 8] for address offset k = 0..3, and all other write bits are 0. Reads extract the same lane into bits 7:0 and clear the bits above.
- R6: Size code 1 (half-word): scan bits 15:0 map to bus bits 31:16 at offset 0 and to bits 15:0 at offset 2. Reads extract these lanes in the same way.
- R7: Size code 2 (word): the data passes through unchanged in both directions.
- R8: A write whose update had scan bit 32 set advances the address by 4 when its acknowledge arrives.
- R9: In the read direction, an update with scan bit 32 set advances the address by 4 and starts the next read at once.
- R10: In the read direction, an update with scan bit 32 clear issues no bus request and leaves the address and read data unchanged.
- R11: An update that arrives while bus_req waits for acknowledge is held and issued exactly once after the acknowledge. No transfer is lost or repeated.
- R12: While bus_req is high and bus_ack is low, bus_req, bus_write, bus_size, bus_addr and bus_wdata stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| dr_capture | input | 1 | TAP capture strobe for this data register |
| dr_shift | input | 1 | TAP shift strobe |
| dr_update | input | 1 | TAP update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the scan path |
| cmd_load | input | 1 | Command register loaded this cycle |
| cmd_addr | input | 32 | Start address from the command register |
| cmd_write | input | 1 | 1 = write direction, 0 = read direction |
| cmd_size | input | 2 | 0 byte, 1 half-word, 2 word |
| bus_req | output | 1 | Transfer request, held until acknowledge |
| bus_write | output | 1 | Request is a write |
| bus_size | output | 2 | Transfer size code |
| bus_addr | output | 32 | Transfer address |
| bus_wdata | output | 32 | Lane-placed write data |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| bus_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
The assertions assume a well-behaved environment. The capture, shift and update strobes are never active together. bus_ack comes only while bus_req is high. A command load arrives only while the port is idle. No more than one update waits at a time. The bench keeps to these rules by construction. Its bus responder acknowledges only a pending request, after a delay it picks from a fixed-seed random source or sets long on purpose. Every scan is a full capture, 33 shifts and update sequence. The bench waits for the port to be idle before each command load. In the hold-off test, exactly two updates are stacked against one slow acknowledge.

// File: rtl/jdr_pkg.sv
package jdr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int SCAN_W = DATA_W + 1;
    localparam int STEP   = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;
endpackage

// File: rtl/jdr_scan_path.sv
module jdr_scan_path
    import jdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              shift,
    input  logic              tdi,
    input  logic [DATA_W-1:0] cap_data,
    output logic [SCAN_W-1:0] path,
    output logic              tdo
);
    typedef struct packed {
        logic [SCAN_W-1:0] sr;
    } scan_s;

    scan_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (capture) begin
            s_d.sr = {1'b0, cap_data};
        end else if (shift) begin
            s_d.sr = {tdi, s_q.sr[SCAN_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign path = s_q.sr;
    assign tdo  = s_q.sr[0];

    // R2: serial input lands at the top bit
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !capture) |=> (path[SCAN_W-1] == $past(tdi)));
    // R2: previous bit 1 becomes the new output bit
    p_shift_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !capture) |=> (tdo == $past(path[1])));
    // R2: capture clears the streaming flag
    p_capture_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (path[SCAN_W-1] == 1'b0));
endmodule

// File: rtl/jdr_lane.sv
module jdr_lane
    import jdr_pkg::*;
(
    input  size_e             size,
    input  logic [1:0]        offset,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] lane_wdata,
    input  logic [DATA_W-1:0] lane_rdata,
    output logic [DATA_W-1:0] host_rdata
);
    logic [4:0] byte_sh;
    logic [4:0] half_sh;

    always_comb begin
        byte_sh = {2'd3 - offset, 3'b000};
        half_sh = offset[1] ? 5'd0 : 5'd16;
        case (size)
            SZ_BYTE: begin
                lane_wdata = {24'd0, host_wdata[7:0]} << byte_sh;
                host_rdata = (lane_rdata >> byte_sh) & 32'h0000_00FF;
            end
            SZ_HALF: begin
                lane_wdata = {16'd0, host_wdata[15:0]} << half_sh;
                host_rdata = (lane_rdata >> half_sh) & 32'h0000_FFFF;
            end
            default: begin
                lane_wdata = host_wdata;
                host_rdata = lane_rdata;
            end
        endcase
    end

    // R5: a byte write touches exactly one lane
    always_comb begin
        if (size == SZ_BYTE) begin
            a_byte_lane_r5: assert ((lane_wdata & ~(32'hFF << byte_sh)) == '0);
        end
    end
endmodule

// File: rtl/jdr_bus_ctrl.sv
module jdr_bus_ctrl
    import jdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_write,
    input  logic [1:0]        cmd_size,
    input  logic              upd,
    input  logic [SCAN_W-1:0] upd_path,
    output logic [DATA_W-1:0] sel_data,
    input  logic [DATA_W-1:0] packed_wdata,
    input  logic [DATA_W-1:0] extracted_rdata,
    output size_e             cur_size,
    output logic [1:0]        cur_offset,
    output logic [DATA_W-1:0] last_rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack
);
    typedef struct packed {
        logic              req;
        logic              write;
        size_e             size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wseq;
        logic              pend;
        logic [DATA_W-1:0] pend_data;
        logic              pend_seq;
        logic [DATA_W-1:0] rdata;
    } ctrl_s;

    ctrl_s c_d, c_q;
    logic  go;
    logic  go_seq;

    always_comb begin
        sel_data = c_q.pend ? c_q.pend_data : upd_path[DATA_W-1:0];
        go_seq   = c_q.pend ? c_q.pend_seq  : upd_path[SCAN_W-1];
        go       = !c_q.req && !cmd_load && (upd || c_q.pend);
    end

    always_comb begin
        c_d = c_q;
        if (c_q.req) begin
            if (bus_ack) begin
                c_d.req = 1'b0;
                if (c_q.write) begin
                    if (c_q.wseq) c_d.addr = c_q.addr + ADDR_W'(STEP);
                end else begin
                    c_d.rdata = extracted_rdata;
                end
            end
            if (upd) begin
                c_d.pend      = 1'b1;
                c_d.pend_data = upd_path[DATA_W-1:0];
                c_d.pend_seq  = upd_path[SCAN_W-1];
            end
        end else if (cmd_load) begin
            c_d.addr  = cmd_addr;
            c_d.write = cmd_write;
            c_d.size  = size_e'(cmd_size);
            c_d.req   = !cmd_write;
            c_d.pend  = 1'b0;
        end else if (go) begin
            c_d.pend = 1'b0;
            if (c_q.write) begin
                c_d.req   = 1'b1;
                c_d.wdata = packed_wdata;
                c_d.wseq  = go_seq;
            end else if (go_seq) begin
                c_d.addr = c_q.addr + ADDR_W'(STEP);
                c_d.req  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cur_size   = c_q.size;
    assign cur_offset = c_q.addr[1:0];
    assign last_rdata = c_q.rdata;
    assign bus_req    = c_q.req;
    assign bus_write  = c_q.write;
    assign bus_size   = c_q.size;
    assign bus_addr   = c_q.addr;
    assign bus_wdata  = c_q.wdata;

    // R12: request fields hold while waiting
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata)
                                   && $stable(bus_write) && $stable(bus_size)));
    // R8: streamed write steps the address on acknowledge
    p_write_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_write && bus_ack && c_q.wseq)
        |=> (bus_addr == $past(bus_addr) + ADDR_W'(STEP)));
    // R9: streamed read update steps and requests immediately
    p_read_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !bus_write && go_seq)
        |=> (bus_req && bus_addr == $past(bus_addr) + ADDR_W'(STEP)));
    // R10: non-streamed read update is idle
    p_read_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !bus_write && !go_seq) |=> (!bus_req && $stable(bus_addr)));
    // R11: a held update is consumed as soon as the port frees
    p_pend_served_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.pend && !bus_req && !cmd_load) |=> !c_q.pend);
    // R11: only one update waits at a time (environment rule)
    p_single_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd && c_q.pend));
    // R3: read command raises a request next cycle
    p_read_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !bus_req && !cmd_write) |=> (bus_req && !bus_write));
endmodule

// File: rtl/jtag_dr_bus_access.sv
module jtag_dr_bus_access
    import jdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dr_capture,
    input  logic        dr_shift,
    input  logic        dr_update,
    input  logic        tdi,
    output logic        tdo,
    input  logic        cmd_load,
    input  logic [31:0] cmd_addr,
    input  logic        cmd_write,
    input  logic [1:0]  cmd_size,
    output logic        bus_req,
    output logic        bus_write,
    output logic [1:0]  bus_size,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack
);
    logic [SCAN_W-1:0] path;
    logic [DATA_W-1:0] sel_data;
    logic [DATA_W-1:0] packed_wdata;
    logic [DATA_W-1:0] extracted_rdata;
    logic [DATA_W-1:0] last_rdata;
    size_e             cur_size;
    logic [1:0]        cur_offset;

    jdr_scan_path u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (dr_capture),
        .shift    (dr_shift),
        .tdi      (tdi),
        .cap_data (last_rdata),
        .path     (path),
        .tdo      (tdo)
    );

    jdr_lane u_lane (
        .size       (cur_size),
        .offset     (cur_offset),
        .host_wdata (sel_data),
        .lane_wdata (packed_wdata),
        .lane_rdata (bus_rdata),
        .host_rdata (extracted_rdata)
    );

    jdr_bus_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_load        (cmd_load),
        .cmd_addr        (cmd_addr),
        .cmd_write       (cmd_write),
        .cmd_size        (cmd_size),
        .upd             (dr_update),
        .upd_path        (path),
        .sel_data        (sel_data),
        .packed_wdata    (packed_wdata),
        .extracted_rdata (extracted_rdata),
        .cur_size        (cur_size),
        .cur_offset      (cur_offset),
        .last_rdata      (last_rdata),
        .bus_req         (bus_req),
        .bus_write       (bus_write),
        .bus_size        (bus_size),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_ack         (bus_ack)
    );

    // R2: strobes are exclusive (environment rule)
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dr_capture, dr_shift, dr_update}) <= 1);
    // R12: acknowledge only answers a live request (environment rule)
    p_ack_has_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> bus_req);
endmodule

// File: tb/jtag_dr_bus_access_test.sv
module jtag_dr_bus_access_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic        cmd_load = 1'b0, cmd_write = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [1:0]  cmd_size = '0;
    logic        bus_req, bus_write;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    jtag_dr_bus_access uut (.*);

    // bus responder state
    logic [31:0] mem [0:63];
    int          ack_delay = 1;
    bit          rand_delay = 1'b0;
    int          n_tr = 0;
    logic [31:0] lg_addr, lg_wdata;
    logic        lg_write;
    logic [1:0]  lg_size;
    logic [31:0] wr_addr_log [0:15];
    logic [31:0] wr_data_log [0:15];
    int          n_wr = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'd0: lane_mask = 32'hFF00_0000 >> (8 * off);
            2'd1: lane_mask = off[1] ? 32'h0000_FFFF : 32'hFFFF_0000;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] exp_bus(input logic [1:0] sz, input logic [1:0] off, input logic [31:0] v);
        case (sz)
            2'd0: exp_bus = {v[7:0], 24'd0} >> (8 * off);
            2'd1: exp_bus = off[1] ? {16'd0, v[15:0]} : {v[15:0], 16'd0};
            default: exp_bus = v;
        endcase
    endfunction

    function automatic logic [31:0] trunc(input logic [1:0] sz, input logic [31:0] v);
        case (sz)
            2'd0: trunc = {24'd0, v[7:0]};
            2'd1: trunc = {16'd0, v[15:0]};
            default: trunc = v;
        endcase
    endfunction

    // responder: acknowledges only a pending request
    initial begin
        int cnt = 0;
        logic [31:0] a0 = '0, w0 = '0;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0101_0101 * i;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (rst_n && bus_req) begin
                if (cnt == 0) begin a0 = bus_addr; w0 = bus_wdata; end
                if (cnt >= ack_delay) begin
                    chk(bus_addr == a0 && bus_wdata == w0, "R12", {bus_addr, bus_wdata}, {a0, w0});
                    lg_addr = bus_addr; lg_write = bus_write; lg_size = bus_size; lg_wdata = bus_wdata;
                    if (bus_write) begin
                        mem[bus_addr[7:2]] = (mem[bus_addr[7:2]] & ~lane_mask(bus_size, bus_addr[1:0]))
                                           | (bus_wdata & lane_mask(bus_size, bus_addr[1:0]));
                        if (n_wr < 16) begin
                            wr_addr_log[n_wr] = bus_addr; wr_data_log[n_wr] = bus_wdata;
                        end
                        n_wr++;
                    end else begin
                        bus_rdata = mem[bus_addr[7:2]];
                    end
                    n_tr++;
                    bus_ack = 1'b1;
                    cnt = 0;
                    if (rand_delay) ack_delay = $urandom_range(0, 3);
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 2) begin
            @(negedge clk);
            if (!bus_req && !bus_ack) quiet++; else quiet = 0;
        end
    endtask

    task automatic command(input logic [31:0] a, input logic w, input logic [1:0] sz);
        @(negedge clk);
        cmd_addr = a; cmd_write = w; cmd_size = sz; cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    task automatic scan(input logic [32:0] din, output logic [32:0] dout);
        @(negedge clk);
        dr_capture = 1'b1;
        @(negedge clk);
        dr_capture = 1'b0;
        for (int i = 0; i < 33; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            dr_shift = 1'b1;
            @(negedge clk);
        end
        dr_shift = 1'b0;
        dr_update = 1'b1;
        @(negedge clk);
        dr_update = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [32:0] so;
        logic [31:0] v, a, base;
        logic [1:0]  sz, off;
        int          t0, w0;
        void'($urandom(32'd5150));

        repeat (3) @(negedge clk);
        chk(bus_req == 1'b0, "R1", bus_req, 0);
        chk(tdo == 1'b0, "R1", tdo, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 R7: word write, then read back through capture (R2 R3)
        command(32'h10, 1'b1, 2'd2);
        scan({1'b0, 32'hCAFE_F00D}, so);
        wait_idle();
        chk(lg_write && lg_addr == 32'h10 && lg_size == 2'd2, "R4", {lg_write, lg_size, lg_addr}, {1'b1, 2'd2, 32'h10});
        chk(lg_wdata == 32'hCAFE_F00D, "R7", lg_wdata, 32'hCAFE_F00D);
        command(32'h10, 1'b0, 2'd2);
        wait_idle();
        chk(!lg_write && lg_addr == 32'h10, "R3", {lg_write, lg_addr}, {1'b0, 32'h10});
        scan(33'd0, so);
        chk(so == {1'b0, 32'hCAFE_F00D}, "R2", so, {1'b0, 32'hCAFE_F00D});

        // R5: byte lanes
        for (int k = 0; k < 4; k++) begin
            v = 32'h5A00_0000 | (32'h11 * (k + 1));
            command(32'h20 + k, 1'b1, 2'd0);
            scan({1'b0, v}, so);
            wait_idle();
            chk(lg_wdata == exp_bus(2'd0, 2'(k), v), "R5", lg_wdata, exp_bus(2'd0, 2'(k), v));
            command(32'h20 + k, 1'b0, 2'd0);
            wait_idle();
            scan(33'd0, so);
            chk(so == {1'b0, trunc(2'd0, v)}, "R5", so, {1'b0, trunc(2'd0, v)});
        end

        // R6: half-word lanes
        for (int k = 0; k < 4; k += 2) begin
            v = 32'hEE00_0000 | (32'h1234 + k);
            command(32'h30 + k, 1'b1, 2'd1);
            scan({1'b0, v}, so);
            wait_idle();
            chk(lg_wdata == exp_bus(2'd1, 2'(k), v), "R6", lg_wdata, exp_bus(2'd1, 2'(k), v));
            command(32'h30 + k, 1'b0, 2'd1);
            wait_idle();
            scan(33'd0, so);
            chk(so == {1'b0, trunc(2'd1, v)}, "R6", so, {1'b0, trunc(2'd1, v)});
        end

        // R8: streamed writes
        rand_delay = 1'b1;
        base = 32'h40;
        command(base, 1'b1, 2'd2);
        for (int k = 0; k < 4; k++) begin
            v = $urandom;
            scan({1'b1, v}, so);
            wait_idle();
            chk(lg_addr == base + 4 * k && lg_wdata == v, "R8", {lg_addr, lg_wdata}, {base + 4 * k, v});
        end

        // R9: streamed reads
        command(base, 1'b0, 2'd2);
        wait_idle();
        for (int k = 0; k < 4; k++) begin
            scan({1'b1, 32'd0}, so);
            chk(so == {1'b0, mem[(base[7:2]) + k]}, "R9", so, {1'b0, mem[(base[7:2]) + k]});
            wait_idle();
            chk(lg_addr == base + 4 * (k + 1), "R9", lg_addr, base + 4 * (k + 1));
        end

        // R10: non-streamed read update is quiet
        scan({1'b0, 32'd0}, so);
        t0 = n_tr;
        repeat (6) @(negedge clk);
        chk(n_tr == t0 && !bus_req, "R10", n_tr, t0);
        scan({1'b0, 32'd0}, so);
        chk(so == {1'b0, mem[base[7:2] + 4]}, "R10", so, {1'b0, mem[base[7:2] + 4]});

        // R11: second update arrives while the first write is unacknowledged
        rand_delay = 1'b0;
        ack_delay = 50;
        command(32'h60, 1'b1, 2'd2);
        w0 = n_wr;
        scan({1'b1, 32'hAAAA_0001}, so);
        scan({1'b0, 32'hBBBB_0002}, so);
        wait_idle();
        repeat (4) @(negedge clk);
        chk(n_wr == w0 + 2, "R11", n_wr, w0 + 2);
        chk(wr_addr_log[w0] == 32'h60 && wr_data_log[w0] == 32'hAAAA_0001, "R11",
            {wr_addr_log[w0], wr_data_log[w0]}, {32'h60, 32'hAAAA_0001});
        chk(wr_addr_log[w0 + 1] == 32'h64 && wr_data_log[w0 + 1] == 32'hBBBB_0002, "R11",
            {wr_addr_log[w0 + 1], wr_data_log[w0 + 1]}, {32'h64, 32'hBBBB_0002});
        ack_delay = 1;
        rand_delay = 1'b1;

        // random mixed sizes and offsets: write then read back
        for (int n = 0; n < 20; n++) begin
            sz  = 2'($urandom_range(0, 2));
            off = 2'($urandom_range(0, 3));
            if (sz == 2'd1) off = {off[1], 1'b0};
            if (sz == 2'd2) off = 2'd0;
            a = 32'h80 + 4 * $urandom_range(0, 15) + off;
            v = $urandom;
            command(a, 1'b1, sz);
            scan({1'b0, v}, so);
            wait_idle();
            chk(lg_wdata == exp_bus(sz, off, v), sz == 0 ? "R5" : (sz == 1 ? "R6" : "R7"),
                lg_wdata, exp_bus(sz, off, v));
            command(a, 1'b0, sz);
            wait_idle();
            scan(33'd0, so);
            chk(so == {1'b0, trunc(sz, v)}, "R3", so, {1'b0, trunc(sz, v)});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule